// File: doc/BRIEF.md
# Strap-Addressed I2C Control Register Target

This block is an I2C target that lets a host processor read and write a small file of 8-bit control registers. The three strap inputs choose its 7-bit device address through a fixed, non-linear mapping, so up to eight of these targets can share one bus. The host sends the address byte with a write direction, then a register index byte, then any number of data bytes. The index advances after every data byte. For a read, the host first sets the index with a write, issues a repeated START, and then reads bytes back. The index keeps advancing on each byte read.

The whole register file drives the surrounding control logic in parallel. Two bits of the control register at index 6 are also brought out as dedicated outputs: a software-control enable and an output enable. All registers clear to zero at reset, so both of these outputs start low. The block runs on a system clock that is much faster than SCL. It never stretches the clock. It drives the bus only by pulling SDA low through an output-enable signal.

Top module: `strap_i2c_regfile`

## Requirements
- R1: The 8-bit write address (7-bit address followed by R/W=0) is set by `strap_i` as follows: 000→0x94, 001→0x96, 010→0x9C, 011→0x9E, 100→0xD4, 101→0xD6, 110→0xDC, 111→0xDE. The target ACKs its own address under every strap value.
- R2: The target does not ACK an address byte that differs from its own. It then leaves SDA released for all following bytes, and the register file is unchanged, until the next START.
- R3: After a write address, the first byte loads the register index (the low log2(NUM_REGS) bits). Each following byte is stored at the index, and the index then increments modulo NUM_REGS, so index 7 is followed by index 0. Every byte of an addressed write is ACKed by pulling SDA low during the ninth clock.
- R4: After a read address, the target returns the register at the current index, MSB first, with SDA pulled low for 0 bits. After each byte the index increments. A read that follows a STOP continues from the index left by the last access.
- R5: If the host NACKs a read byte, the transfer ends and SDA is released. It stays released on further SCL clocks until the next START or STOP.
- R6: A START seen in any state, including a repeated START, releases SDA and restarts address reception.
- R7: A STOP seen in any state returns the target to idle with SDA released. A partly received data byte is discarded without being written.
- R8: SCL and SDA each pass through a two-flop synchroniser and a majority vote over three system-clock samples. A pulse on either line that lasts one system clock produces no edge, START or STOP.
- R9: `sw_mode_o` equals bit 7 and `out_en_o` equals bit 5 of the register at index 6.
- R10: While reset is asserted, all registers read 0x00, `sw_mode_o` and `out_en_o` are 0, and SDA is released.
- R11: The target starts pulling SDA low only while the filtered SCL is low. A register changes only in a cycle in which the target is also driving its ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 30 times the SCL rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Address strap; 000 when left at its pull-down default |
| scl_i | input | 1 | Serial clock as seen on the bus |
| sda_i | input | 1 | Serial data as seen on the bus (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 = pull SDA low, 0 = release SDA |
| regs_o | output | NUM_REGS*8 | Register file, index i in bits [8i+7:8i] |
| sw_mode_o | output | 1 | Software-control enable (index 6, bit 7) |
| out_en_o | output | 1 | Output enable (index 6, bit 5) |

## Verification
The assertions assume that the host changes SDA only while SCL is low, except when it signals START or STOP. They also assume that the host never issues a START or STOP while the target is pulling SDA low. The bench's bus tasks follow these rules. They move SDA a quarter bit after the SCL fall, and they place every START and STOP in a window where the target has already released the line. The assertions also assume that strap values stay constant during a transfer. The bench changes the strap only between a STOP and the next START. The one-clock glitches that the bench injects are kept short enough to be filtered out, so they never violate these rules.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_PTR,
        ST_ACK_PTR,
        ST_WDATA,
        ST_ACK_WDATA,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } tgt_state_e;

    // Strap bits sit at fixed positions inside the 7-bit address:
    // s[0] -> bit 0, s[1] -> bit 2, s[2] -> bit 5, remaining bits fixed.
    function automatic logic [6:0] strap_to_addr(input logic [2:0] s);
        return {1'b1, s[2], 1'b0, 1'b1, s[1], 1'b1, s[0]};
    endfunction

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_LEN    = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic line_o
);
    localparam int HALF = VOTE_LEN / 2;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic [VOTE_LEN-1:0]    hist;
        logic                   vote;
    } flt_t;

    flt_t q, d;
    int   ones;

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_STAGES-2:0], line_i};
        d.hist = {q.hist[VOTE_LEN-2:0], q.sync[SYNC_STAGES-1]};
        ones   = 0;
        for (int i = 0; i < VOTE_LEN; i++) begin
            if (q.hist[i]) ones++;
        end
        d.vote = (ones > HALF);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= d;
    end

    assign line_o = q.vote;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_o,
    output logic stop_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } ev_t;

    ev_t q, d;

    always_comb begin
        d.scl = scl_i;
        d.sda = sda_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '1;
        else         q <= d;
    end

    assign start_o = q.scl & scl_i & q.sda & ~sda_i;
    assign stop_o  = q.scl & scl_i & ~q.sda & sda_i;
    assign rise_o  = ~q.scl & scl_i;
    assign fall_o  = q.scl & ~scl_i;
endmodule

// File: rtl/i2c_target_core.sv
module i2c_target_core
    import strap_i2c_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [6:0]               dev_addr_i,
    input  logic                     sda_i,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     rise_i,
    input  logic                     fall_i,
    output logic                     sda_oe_o,
    output logic [NUM_REGS-1:0][7:0] regs_o
);
    localparam int PTR_W = $clog2(NUM_REGS);

    typedef struct packed {
        tgt_state_e              st;
        logic [3:0]              cnt;
        logic [7:0]              sh;
        logic                    rw;
        logic                    nak;
        logic [PTR_W-1:0]        ptr;
        logic                    oe;
        logic [NUM_REGS-1:0][7:0] regs;
    } core_t;

    core_t q, d;

    always_comb begin
        d = q;
        if (stop_i) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_i) begin
            d.st  = ST_ADDR;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else begin
            case (q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (rise_i && q.cnt != 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_i};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall_i && q.cnt == 4'd8) begin
                        d.cnt = 4'd0;
                        if (q.st == ST_ADDR) begin
                            if (q.sh[7:1] == dev_addr_i) begin
                                d.st = ST_ACK_ADDR;
                                d.oe = 1'b1;
                                d.rw = q.sh[0];
                            end else begin
                                d.st = ST_IGNORE;
                            end
                        end else if (q.st == ST_PTR) begin
                            d.ptr = q.sh[PTR_W-1:0];
                            d.st  = ST_ACK_PTR;
                            d.oe  = 1'b1;
                        end else begin
                            d.regs[q.ptr] = q.sh;
                            d.ptr         = q.ptr + PTR_W'(1);
                            d.st          = ST_ACK_WDATA;
                            d.oe          = 1'b1;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (fall_i) begin
                        if (q.rw) begin
                            d.sh  = q.regs[q.ptr];
                            d.ptr = q.ptr + PTR_W'(1);
                            d.oe  = ~q.regs[q.ptr][7];
                            d.st  = ST_RDATA;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_PTR;
                        end
                    end
                end
                ST_ACK_PTR, ST_ACK_WDATA: begin
                    if (fall_i) begin
                        d.oe = 1'b0;
                        d.st = ST_WDATA;
                    end
                end
                ST_RDATA: begin
                    if (fall_i) begin
                        if (q.cnt == 4'd7) begin
                            d.cnt = 4'd0;
                            d.oe  = 1'b0;
                            d.st  = ST_RACK;
                        end else begin
                            d.cnt = q.cnt + 4'd1;
                            d.sh  = {q.sh[6:0], 1'b0};
                            d.oe  = ~q.sh[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (rise_i) begin
                        d.nak = sda_i;
                    end else if (fall_i) begin
                        if (q.nak) begin
                            d.st = ST_IGNORE;
                        end else begin
                            d.sh  = q.regs[q.ptr];
                            d.ptr = q.ptr + PTR_W'(1);
                            d.oe  = ~q.regs[q.ptr][7];
                            d.st  = ST_RDATA;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;
    assign regs_o   = q.regs;
endmodule

// File: rtl/strap_i2c_regfile.sv
module strap_i2c_regfile
    import strap_i2c_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_LEN    = 3,
    parameter int CTRL_IDX    = 6,
    parameter int SWM_BIT     = 7,
    parameter int OEN_BIT     = 5
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [2:0]            strap_i,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe_o,
    output logic [NUM_REGS*8-1:0] regs_o,
    output logic                  sw_mode_o,
    output logic                  out_en_o
);
    localparam int NLINES = 2;

    logic [NLINES-1:0]        raw_lines;
    logic [NLINES-1:0]        flt_lines;
    logic                     scl_f;
    logic                     sda_f;
    logic                     start_ev;
    logic                     stop_ev;
    logic                     rise_ev;
    logic                     fall_ev;
    logic [NUM_REGS-1:0][7:0] regs_w;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .VOTE_LEN   (VOTE_LEN)
        ) u_filt (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .line_i(raw_lines[g]),
            .line_o(flt_lines[g])
        );
    end

    assign scl_f = flt_lines[0];
    assign sda_f = flt_lines[1];

    i2c_bus_events u_ev (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .scl_i  (scl_f),
        .sda_i  (sda_f),
        .start_o(start_ev),
        .stop_o (stop_ev),
        .rise_o (rise_ev),
        .fall_o (fall_ev)
    );

    i2c_target_core #(
        .NUM_REGS(NUM_REGS)
    ) u_core (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .dev_addr_i(strap_to_addr(strap_i)),
        .sda_i     (sda_f),
        .start_i   (start_ev),
        .stop_i    (stop_ev),
        .rise_i    (rise_ev),
        .fall_i    (fall_ev),
        .sda_oe_o  (sda_oe_o),
        .regs_o    (regs_w)
    );

    assign regs_o    = regs_w;
    assign sw_mode_o = regs_w[CTRL_IDX][SWM_BIT];
    assign out_en_o  = regs_w[CTRL_IDX][OEN_BIT];
endmodule

// File: rtl/strap_i2c_regfile_chk.sv
module strap_i2c_regfile_chk #(
    parameter int REGS_W = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              scl_f,
    input logic              start_ev,
    input logic              stop_ev,
    input logic              sda_oe,
    input logic [REGS_W-1:0] regs
);
    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        !rst_ni |=> (regs == '0 && !sda_oe)); // R10

    AST_DRIVE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sda_oe) |-> !scl_f); // R11

    AST_WRITE_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(regs) |-> sda_oe); // R3

    AST_STOP_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stop_ev |=> !sda_oe); // R7

    AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_ev |=> !sda_oe); // R6
endmodule

bind strap_i2c_regfile strap_i2c_regfile_chk #(.REGS_W(NUM_REGS*8)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_f   (scl_f),
    .start_ev(start_ev),
    .stop_ev (stop_ev),
    .sda_oe  (sda_oe_o),
    .regs    (regs_o)
);

// File: tb/sim_strap_i2c_regfile.sv
`timescale 1ns/1ps
module sim_strap_i2c_regfile;
    localparam int NREG = 8;
    localparam int QTR  = 30;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      strap = 3'd0;
    logic            scl_m = 1'b1;
    logic            sda_m = 1'b1;
    logic            sda_oe;
    logic [NREG*8-1:0] regs;
    logic            sw_mode;
    logic            out_en;
    logic            sda_line;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit model_on = 0;
    logic [7:0] exp_regs [NREG];

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    strap_i2c_regfile u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .strap_i  (strap),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .regs_o   (regs),
        .sw_mode_o(sw_mode),
        .out_en_o (out_en)
    );

    function automatic logic [7:0] addr8(input logic [2:0] s);
        case (s)
            3'd0: return 8'h94;
            3'd1: return 8'h96;
            3'd2: return 8'h9C;
            3'd3: return 8'h9E;
            3'd4: return 8'hD4;
            3'd5: return 8'hD6;
            3'd6: return 8'hDC;
            default: return 8'hDE;
        endcase
    endfunction

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_regs[i];
        return f;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Per-clock comparison against the behavioural register model (R3, R9, R2)
    always @(negedge clk) begin
        if (rst_n && model_on && !done) begin
            checks++;
            if (regs !== exp_flat() || sw_mode !== exp_regs[6][7] || out_en !== exp_regs[6][5]) begin
                fails++;
                if (fails < 20)
                    $display("FAIL R3/R9 model regs actual=%0h expected=%0h sw=%0b oe=%0b",
                             regs, exp_flat(), sw_mode, out_en);
            end
        end
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(QTR);
        scl_m = 1'b1; wclk(QTR);
        sda_m = 1'b0; wclk(QTR);
        scl_m = 1'b0; wclk(QTR);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(QTR);
        scl_m = 1'b1; wclk(QTR);
        sda_m = 1'b1; wclk(2*QTR);
    endtask

    task automatic put_bit(input logic b, input bit glitch);
        sda_m = b; wclk(QTR);
        if (glitch) begin
            scl_m = 1'b1; wclk(1); scl_m = 1'b0;
        end
        scl_m = 1'b1; wclk(QTR);
        if (glitch) begin
            sda_m = ~b; wclk(1); sda_m = b;
        end
        wclk(QTR);
        scl_m = 1'b0; wclk(QTR);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wclk(QTR);
        scl_m = 1'b1; wclk(QTR);
        b = sda_line; wclk(QTR);
        scl_m = 1'b0; wclk(QTR);
    endtask

    task automatic wbyte(input logic [7:0] v, input bit glitch, output bit acked);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(v[i], glitch);
        get_bit(a);
        acked = (a == 1'b0);
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(mack ? 1'b0 : 1'b1, 1'b0);
    endtask

    // Modelled write of one data byte that the target must store
    task automatic wdata(input int idx, input logic [7:0] v, input bit glitch, input string req);
        bit ak;
        model_on = 0;
        wbyte(v, glitch, ak);
        exp_regs[idx % NREG] = v;
        model_on = 1;
        check(ak, req, 64'(ak), 64'd1);
    endtask

    task automatic set_ptr(input int p, input string req);
        bit ak;
        bus_start();
        wbyte(addr8(strap), 1'b0, ak); check(ak, req, 64'(ak), 64'd1);
        wbyte(8'(p), 1'b0, ak);        check(ak, req, 64'(ak), 64'd1);
    endtask

    initial begin
        logic [7:0] rd;
        logic       b;
        bit         ak;
        for (int i = 0; i < NREG; i++) exp_regs[i] = 8'h00;

        // R10: reset state
        wclk(5);
        check(regs == '0, "R10 regs", 64'(regs), 64'd0);
        check(!sda_oe && !sw_mode && !out_en, "R10 outputs", {61'd0, sda_oe, sw_mode, out_en}, 64'd0);
        rst_n = 1'b1;
        wclk(10);
        model_on = 1;

        // R1: every strap value gives its own address an ACK
        for (int s = 0; s < 8; s++) begin
            strap = 3'(s);
            wclk(5);
            bus_start();
            wbyte(addr8(3'(s)), 1'b0, ak);
            check(ak, $sformatf("R1 strap %0d", s), 64'(ak), 64'd1);
            bus_stop();
        end
        strap = 3'd0;
        wclk(5);

        // R3: index then auto-incrementing writes
        set_ptr(2, "R3 hdr");
        wdata(2, 8'h11, 1'b0, "R3 ack");
        wdata(3, 8'h22, 1'b0, "R3 ack");
        wdata(4, 8'h33, 1'b0, "R3 ack");
        bus_stop();
        check(regs[39:16] == 24'h332211, "R3 stored", 64'(regs[39:16]), 64'h332211);

        // R6/R4/R5: index write, repeated START, read three bytes
        set_ptr(2, "R6 hdr");
        bus_start();
        wbyte(addr8(strap) | 8'h01, 1'b0, ak);
        check(ak, "R6 read addr after repeated START", 64'(ak), 64'd1);
        rbyte(1'b1, rd); check(rd == 8'h11, "R4 byte0", 64'(rd), 64'h11);
        rbyte(1'b1, rd); check(rd == 8'h22, "R4 byte1", 64'(rd), 64'h22);
        rbyte(1'b0, rd); check(rd == 8'h33, "R4 byte2", 64'(rd), 64'h33);
        check(!sda_oe, "R5 release after NACK", 64'(sda_oe), 64'd0);
        get_bit(b);
        check(b == 1'b1, "R5 no drive after NACK", 64'(b), 64'd1);
        bus_stop();

        // R3: index wraps from 7 to 0
        set_ptr(7, "R3 wrap hdr");
        wdata(7, 8'h77, 1'b0, "R3 wrap");
        wdata(0, 8'h5A, 1'b0, "R3 wrap");
        bus_stop();
        check(regs[7:0] == 8'h5A, "R3 wrap to 0", 64'(regs[7:0]), 64'h5A);

        // R9: control bits of index 6
        set_ptr(6, "R9 hdr");
        wdata(6, 8'hA0, 1'b0, "R9 ack");
        bus_stop();
        check(sw_mode && out_en, "R9 both set", {62'd0, sw_mode, out_en}, 64'd3);
        set_ptr(6, "R9 hdr");
        wdata(6, 8'h80, 1'b0, "R9 ack");
        bus_stop();
        check(sw_mode && !out_en, "R9 only sw", {62'd0, sw_mode, out_en}, 64'd2);

        // R2: wrong address ignored until the next START
        bus_start();
        wbyte(8'h96, 1'b0, ak); check(!ak, "R2 NACK wrong addr", 64'(ak), 64'd0);
        wbyte(8'h01, 1'b0, ak); check(!ak, "R2 ignore byte", 64'(ak), 64'd0);
        wbyte(8'h99, 1'b0, ak); check(!ak, "R2 ignore byte", 64'(ak), 64'd0);
        bus_stop();
        check(regs[15:8] == exp_regs[1], "R2 regs unchanged", 64'(regs[15:8]), 64'(exp_regs[1]));
        strap = 3'd5;
        wclk(5);
        bus_start();
        wbyte(addr8(3'd4), 1'b0, ak); check(!ak, "R2 neighbour addr", 64'(ak), 64'd0);
        bus_stop();
        strap = 3'd0;
        wclk(5);

        // R7: STOP in the middle of a data byte discards it
        set_ptr(3, "R7 hdr");
        for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0);
        bus_stop();
        check(regs[31:24] == 8'h22, "R7 partial byte dropped", 64'(regs[31:24]), 64'h22);
        bus_start();
        wbyte(addr8(strap) | 8'h01, 1'b0, ak);
        check(ak, "R7 idle then addressed", 64'(ak), 64'd1);
        rbyte(1'b0, rd);
        check(rd == 8'h22, "R4 read continues at index", 64'(rd), 64'h22);
        bus_stop();

        // R8: one-clock glitches on SCL and SDA in every bit
        set_ptr(1, "R8 hdr");
        wdata(1, 8'hC3, 1'b1, "R8 glitch ack");
        bus_stop();
        check(regs[15:8] == 8'hC3, "R8 glitched byte", 64'(regs[15:8]), 64'hC3);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule